// File: doc/BRIEF.md
# North-Bridge Reference Ramp Generator

This block produces the 8-bit digital code that sets the north-bridge regulator reference, where one LSB is 8 mV. The code moves toward a target formed from a base value and a signed offset, both counted in 12.5 mV units. A step-mode input selects how the code gets there. It can load the target at once, or it can walk one LSB per 100 µs or one LSB per 200 µs. A manual flag makes the base value alone set the reference, loaded at once. A microsecond tick from the surrounding chip paces all timed stepping.

After reset, and again each time the processor leaves parallel-VID operation, the block runs a soft start. The code climbs from zero at the 100 µs rate, whatever mode is selected, until it first meets the target. An active-low enable for the external north-bridge regulator goes low once the reference is above 0.3 V. While the processor runs in parallel-VID mode, the reference is held at zero and the enable is held high. The output code also serves as the readback value, because it is already in 8 mV units.

Top module: `nb_ref_ramp`

## Requirements
- R1: While reset is high, the reference code is 0 and the enable output is 1 (inactive).
- R2: The target code is round(S × 25 / 16), where S = base + offset. The offset is two's complement in 12.5 mV units, and S is taken as 0 when the sum is negative. The result is clamped to the range 38..255 (0.3 V to 2.04 V).
- R3: During soft start, the code rises by one LSB on every 100th microsecond tick, whatever the step mode or the manual flag. Soft start ends when the code first equals the target.
- R4: With step-mode 0 and soft start over, the reference takes the target value one clock after the target changes.
- R5: With step-mode 1, the code moves one LSB toward the target on every 100th tick. Each move is at most one LSB.
- R6: With step-mode 2 or 3, the code moves one LSB toward the target on every 200th tick, in either direction.
- R7: In the stepping modes the code stops exactly at the target and never passes it.
- R8: A target change during a ramp keeps the current code and the tick count already in progress. The ramp simply heads for the new target.
- R9: With the manual flag set and soft start over, the target is computed from the base alone (the offset is ignored) and is loaded in one clock, whatever the step mode.
- R10: The enable output is 0 exactly when the reference code is 38 or more (above 0.3 V). It changes on the same clock edge as the code.
- R11: While parallel-VID mode is set, the code is forced to 0 and the enable to 1 from the next clock on. Leaving that mode starts a new soft start from 0.
- R12: In the stepping modes the code changes only on a clock where the microsecond tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-clock pulse per microsecond |
| base_code | input | 8 | Base target, 12.5 mV per LSB |
| offset_code | input | 8 | Signed offset added to the base, 12.5 mV per LSB |
| step_mode | input | 2 | 0 load, 1 step per 100 µs, 2 or 3 step per 200 µs |
| manual_en | input | 1 | Base alone sets the reference, loaded at once |
| pvi_mode | input | 1 | Processor in parallel-VID mode; outputs disabled |
| ref_code | output | 8 | Reference code, 8 mV per LSB (also the readback value) |
| nb_en_n | output | 1 | Active-low regulator enable |

## Verification
The assertions check every cycle that:
- the enable tracks the 0.3 V level of the code;
- parallel-VID mode forces both outputs off on the next clock;
- in the stepping modes the code moves by at most one LSB, never passes the target, and stays still on clocks without a tick.

Other behaviours show only in the bench scenarios:
- the exact step spacing of 100 and 200 ticks;
- the rounding and clamping of the 12.5 mV to 8 mV conversion;
- soft start ignoring a load-mode request;
- a mid-ramp retarget keeping its partial tick count.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    typedef enum logic [1:0] {
        STEP_LOAD     = 2'd0,
        STEP_FAST     = 2'd1,
        STEP_SLOW     = 2'd2,
        STEP_SLOW_ALT = 2'd3
    } step_mode_e;

    typedef struct packed {
        logic direct;    // load target without ramping
        logic use_fast;  // pace at the short interval
        logic hold;      // pacer idle
    } slew_ctl_t;

    // Scale factor 12.5 mV -> 8 mV is 25/16
    localparam int SCALE_NUM   = 25;
    localparam int SCALE_SHIFT = 4;

    function automatic logic is_stepping(input step_mode_e m, input logic manual);
        return (m != STEP_LOAD) && !manual;
    endfunction

endpackage

// File: rtl/nbr_target.sv
module nbr_target
    import nbr_pkg::*;
#(
    parameter int COARSE_W   = 8,
    parameter int CODE_W     = 8,
    parameter int FLOOR_CODE = 38
) (
    input  logic [COARSE_W-1:0] base_code,
    input  logic [COARSE_W-1:0] offset_code,
    input  logic                manual_en,
    output logic [CODE_W-1:0]   tgt_code
);
    localparam int SUM_W  = COARSE_W + 2;
    localparam int PROD_W = SUM_W + 5;
    localparam logic [PROD_W-1:0] CEIL_P  = PROD_W'((1 << CODE_W) - 1);
    localparam logic [PROD_W-1:0] FLOOR_P = PROD_W'(FLOOR_CODE);

    logic [SUM_W-1:0]  sum_u;
    logic [SUM_W-1:0]  off_ext;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        off_ext = manual_en ? '0 : {{2{offset_code[COARSE_W-1]}}, offset_code};
        sum_u   = {2'b00, base_code} + off_ext;
        if (sum_u[SUM_W-1]) begin
            prod = '0;
        end else begin
            prod = PROD_W'(sum_u) * PROD_W'(SCALE_NUM) + PROD_W'(1 << (SCALE_SHIFT - 1));
        end
        scaled = prod >> SCALE_SHIFT;
        if (scaled > CEIL_P) begin
            tgt_code = CODE_W'(CEIL_P);
        end else if (scaled < FLOOR_P) begin
            tgt_code = CODE_W'(FLOOR_P);
        end else begin
            tgt_code = CODE_W'(scaled);
        end
    end

endmodule

// File: rtl/nbr_pacer.sv
module nbr_pacer #(
    parameter int FAST_US = 100,
    parameter int SLOW_US = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic use_fast,
    input  logic hold,
    output logic step
);
    localparam int SPAN  = (SLOW_US > FAST_US) ? SLOW_US : FAST_US;
    localparam int CNT_W = $clog2(SPAN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = use_fast ? CNT_W'(FAST_US - 1) : CNT_W'(SLOW_US - 1);
    assign step  = us_tick && !hold && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (us_tick) begin
            if (cnt_q >= limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nbr_slew.sv
module nbr_slew #(
    parameter int CODE_W     = 8,
    parameter int FLOOR_CODE = 38
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              pvi_mode,
    input  logic              direct,
    input  logic              step,
    output logic [CODE_W-1:0] ref_code,
    output logic              nb_en_n,
    output logic              soft_on,
    output logic              at_tgt
);
    localparam logic [CODE_W-1:0] THRESH = CODE_W'(FLOOR_CODE);

    logic [CODE_W-1:0] ref_q, ref_d;
    logic              soft_q, soft_d;
    logic              en_n_q;
    logic [CODE_W-1:0] toward;

    assign at_tgt = (ref_q == tgt_code);
    assign toward = (ref_q < tgt_code) ? ref_q + 1'b1 : ref_q - 1'b1;

    always_comb begin
        ref_d  = ref_q;
        soft_d = soft_q;
        if (pvi_mode) begin
            ref_d  = '0;
            soft_d = 1'b1;
        end else if (soft_q) begin
            if (at_tgt) begin
                soft_d = 1'b0;
            end else if (step) begin
                ref_d = toward;
            end
        end else if (direct) begin
            ref_d = tgt_code;
        end else if (step && !at_tgt) begin
            ref_d = toward;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            soft_q <= 1'b1;
            en_n_q <= 1'b1;
        end else begin
            ref_q  <= ref_d;
            soft_q <= soft_d;
            en_n_q <= (ref_d < THRESH);
        end
    end

    assign ref_code = ref_q;
    assign nb_en_n  = en_n_q;
    assign soft_on  = soft_q;

endmodule

// File: rtl/nb_ref_ramp.sv
module nb_ref_ramp
    import nbr_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int COARSE_W   = 8,
    parameter int FAST_US    = 100,
    parameter int SLOW_US    = 200,
    parameter int FLOOR_CODE = 38
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                us_tick,
    input  logic [COARSE_W-1:0] base_code,
    input  logic [COARSE_W-1:0] offset_code,
    input  logic [1:0]          step_mode,
    input  logic                manual_en,
    input  logic                pvi_mode,
    output logic [CODE_W-1:0]   ref_code,
    output logic                nb_en_n
);
    step_mode_e        mode;
    slew_ctl_t         ctl;
    logic [CODE_W-1:0] tgt_code;
    logic              step;
    logic              soft_on;
    logic              at_tgt;

    assign mode = step_mode_e'(step_mode);

    always_comb begin
        ctl.direct   = !is_stepping(mode, manual_en);
        ctl.use_fast = soft_on || (mode == STEP_FAST);
        ctl.hold     = pvi_mode || at_tgt;
    end

    nbr_target #(
        .COARSE_W  (COARSE_W),
        .CODE_W    (CODE_W),
        .FLOOR_CODE(FLOOR_CODE)
    ) u_target (
        .base_code  (base_code),
        .offset_code(offset_code),
        .manual_en  (manual_en),
        .tgt_code   (tgt_code)
    );

    nbr_pacer #(
        .FAST_US(FAST_US),
        .SLOW_US(SLOW_US)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .us_tick (us_tick),
        .use_fast(ctl.use_fast),
        .hold    (ctl.hold),
        .step    (step)
    );

    nbr_slew #(
        .CODE_W    (CODE_W),
        .FLOOR_CODE(FLOOR_CODE)
    ) u_slew (
        .clk     (clk),
        .rst     (rst),
        .tgt_code(tgt_code),
        .pvi_mode(pvi_mode),
        .direct  (ctl.direct),
        .step    (step),
        .ref_code(ref_code),
        .nb_en_n (nb_en_n),
        .soft_on (soft_on),
        .at_tgt  (at_tgt)
    );

endmodule

// File: rtl/nb_ref_ramp_chk.sv
module nb_ref_ramp_chk #(
    parameter int CODE_W     = 8,
    parameter int FLOOR_CODE = 38
) (
    input logic              clk,
    input logic              rst,
    input logic              us_tick,
    input logic [1:0]        step_mode,
    input logic              manual_en,
    input logic              pvi_mode,
    input logic [CODE_W-1:0] ref_code,
    input logic              nb_en_n,
    input logic [CODE_W-1:0] tgt_code
);
    logic stepping;
    assign stepping = !pvi_mode && (step_mode != 2'd0) && !manual_en;

    AST_ENABLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        nb_en_n == (ref_code < CODE_W'(FLOOR_CODE))); // R10

    AST_PVI_OFF: assert property (@(posedge clk) disable iff (rst)
        pvi_mode |=> (ref_code == '0) && nb_en_n); // R11

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        stepping |=> (ref_code == $past(ref_code))
                  || (ref_code == CODE_W'($past(ref_code) + 1'b1))
                  || (ref_code == CODE_W'($past(ref_code) - 1'b1))); // R5

    AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (rst)
        (stepping && (ref_code < tgt_code)) |=> (ref_code <= $past(tgt_code))); // R7

    AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (rst)
        (stepping && (ref_code > tgt_code)) |=> (ref_code >= $past(tgt_code))); // R7

    AST_TICK_GATE: assert property (@(posedge clk) disable iff (rst)
        (stepping && !us_tick) |=> $stable(ref_code)); // R12

endmodule

bind nb_ref_ramp nb_ref_ramp_chk #(
    .CODE_W    (CODE_W),
    .FLOOR_CODE(FLOOR_CODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .us_tick  (us_tick),
    .step_mode(step_mode),
    .manual_en(manual_en),
    .pvi_mode (pvi_mode),
    .ref_code (ref_code),
    .nb_en_n  (nb_en_n),
    .tgt_code (tgt_code)
);

// File: tb/nb_ref_ramp_test.sv
module nb_ref_ramp_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       us_tick;
    logic [7:0] base_code;
    logic [7:0] offset_code;
    logic [1:0] step_mode;
    logic       manual_en;
    logic       pvi_mode;
    logic [7:0] ref_code;
    logic       nb_en_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nb_ref_ramp uut (
        .clk        (clk),
        .rst        (rst),
        .us_tick    (us_tick),
        .base_code  (base_code),
        .offset_code(offset_code),
        .step_mode  (step_mode),
        .manual_en  (manual_en),
        .pvi_mode   (pvi_mode),
        .ref_code   (ref_code),
        .nb_en_n    (nb_en_n)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; us_tick = 1'b1; base_code = 8'd24; offset_code = 8'd0;
        step_mode = 2'd2; manual_en = 1'b0; pvi_mode = 1'b0;
        edges(3);
        chk("R1 ref", ref_code, 0);
        chk("R1 en_n", nb_en_n, 1);
        rst = 1'b0;
    endtask

    task automatic t_soft_start;
        // target 24 * 25/16 = 37.5 -> 38, slow mode selected but soft start is fast
        edges(99);   chk("R3 before first step", ref_code, 0);
        edges(1);    chk("R3 first step at 100", ref_code, 1);
        edges(3699); chk("R3 code 37", ref_code, 37);
        chk("R10 below threshold", nb_en_n, 1);
        edges(1);    chk("R3 reached 38", ref_code, 38);
        chk("R10 above threshold", nb_en_n, 0);
        edges(3);
    endtask

    task automatic t_direct;
        step_mode = 2'd0; base_code = 8'd100;
        edges(1); chk("R4 load 100->156", ref_code, 156);
        base_code = 8'd101;
        edges(1); chk("R2 round 101->158", ref_code, 158);
        offset_code = 8'hFB;
        edges(1); chk("R2 offset -5 ->150", ref_code, 150);
        base_code = 8'd10; offset_code = 8'd0;
        edges(1); chk("R2 clamp low", ref_code, 38);
        base_code = 8'd200;
        edges(1); chk("R2 clamp high", ref_code, 255);
        base_code = 8'd3; offset_code = 8'hF6;
        edges(1); chk("R2 negative sum", ref_code, 38);
        chk("R10 at floor", nb_en_n, 0);
    endtask

    task automatic t_manual;
        step_mode = 2'd2; manual_en = 1'b1; base_code = 8'd64; offset_code = 8'd20;
        edges(1); chk("R9 base only loaded", ref_code, 100);
    endtask

    task automatic t_fast_up;
        manual_en = 1'b0; step_mode = 2'd1; offset_code = 8'd0;
        edges(1); chk("R5 settled", ref_code, 100);
        base_code = 8'd66;   // 103
        edges(99);  chk("R5 no step yet", ref_code, 100);
        edges(1);   chk("R5 step at 100", ref_code, 101);
        edges(200); chk("R5 reached 103", ref_code, 103);
        edges(100); chk("R7 stays at target", ref_code, 103);
    endtask

    task automatic t_slow_down;
        step_mode = 2'd2; base_code = 8'd64;  // 100
        edges(199); chk("R6 no step yet", ref_code, 103);
        edges(1);   chk("R6 step at 200", ref_code, 102);
        edges(400); chk("R6 reached 100", ref_code, 100);
        edges(200); chk("R7 stays at target", ref_code, 100);
    endtask

    task automatic t_retarget;
        step_mode = 2'd1; base_code = 8'd80;  // 125
        edges(150); chk("R8 ramped one", ref_code, 101);
        base_code = 8'd64;                    // back to 100
        edges(49);  chk("R8 count kept", ref_code, 101);
        edges(1);   chk("R8 stepped at old phase", ref_code, 100);
    endtask

    task automatic t_tick_gate;
        base_code = 8'd66; us_tick = 1'b0;
        edges(300); chk("R12 no tick no move", ref_code, 100);
        us_tick = 1'b1;
        edges(99);  chk("R12 counting", ref_code, 100);
        edges(1);   chk("R12 step after ticks", ref_code, 101);
    endtask

    task automatic t_pvi;
        pvi_mode = 1'b1;
        edges(1);  chk("R11 ref off", ref_code, 0);
        chk("R11 en_n off", nb_en_n, 1);
        step_mode = 2'd0; base_code = 8'd100;
        edges(10); chk("R11 held off", ref_code, 0);
        pvi_mode = 1'b0;
        edges(1);  chk("R3 soft start ignores load", ref_code, 0);
        edges(99); chk("R3 restart first step", ref_code, 1);
        chk("R10 low code", nb_en_n, 1);
    endtask

    initial begin
        t_reset();
        t_soft_start();
        t_direct();
        t_manual();
        t_fast_up();
        t_slow_down();
        t_retarget();
        t_tick_gate();
        t_pvi();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule